// File: doc/BRIEF.md
# Two-Wire Slave Byte Receiver with Clock Hold

This block is the receive-only slave side of a two-wire serial bus. It samples the clock and data lines and finds start and stop conditions. It keeps a flag that shows whether the bus is busy. After each start it gathers the first byte and compares it with the programmed own address. When the address matches and the direction bit asks for a write, the block acknowledges the byte and then accepts data bytes. The most significant bit arrives first.

Each accepted byte is acknowledged on the ninth clock, unless the host has inhibited the acknowledge. At that clock the byte is copied into the receive register and an interrupt flag is raised. From the falling edge of the ninth clock the block pulls the clock line low and keeps it there until the host strobes a read of the receive register. That read frees the clock line, and the next byte can then start. The host clears the flag with a one-cycle clear pulse.

Both bus outputs are open-drain requests. A 1 pulls the line low and a 0 releases it. The block never drives a line high.

Top module: `i2c_slave_rx`

## Requirements
- R1: A falling data line while the clock line is high (start) sets `bus_busy` one cycle after it is detected, whether or not the block is enabled. Reset clears `bus_busy`, `irq_flag`, both pull outputs and `rx_data`.
- R2: A rising data line while the clock line is high (stop) clears `bus_busy`, returns the block to idle and releases both lines.
- R3: In the first byte after a start, bits 7..1 are compared with `own_addr` and bit 0 is the direction bit, where 0 means write. Only a match with direction 0 is acknowledged. Any other first byte gets no data-line pull, no flag and no clock hold up to the next start or stop.
- R4: When `cfg_ack_inhibit` is 1, the data line stays released on the ninth clock of an accepted byte. The byte is still delivered to `rx_data` and still raises the flag.
- R5: `irq_flag` is set at the rising edge of the ninth clock of every accepted byte, the address byte included. `irq` is 1 exactly when `irq_flag` and `cfg_irq_en` are both 1.
- R6: From the falling edge of the ninth clock, `scl_pull_o` stays 1 until a `data_rd` pulse. The cycle after that pulse it is 0, and reception of the next byte begins.
- R7: A `flag_clr` pulse clears `irq_flag`. Clearing the flag and reading the data repeats for any number of bytes.
- R8: Bytes are shifted in most significant bit first. `rx_data` holds the full byte, and for the address byte that includes the direction bit.
- R9: While `cfg_enable` is 0 the block pulls neither line, raises no flag and acknowledges no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed clock line |
| sda_i | input | 1 | Sensed data line |
| scl_pull_o | output | 1 | 1 pulls the clock line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cfg_enable | input | 1 | Slave enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_ack_inhibit | input | 1 | 1 suppresses the acknowledge |
| own_addr | input | ADDR_W | Programmed slave address |
| flag_clr | input | 1 | Pulse that clears the interrupt flag |
| data_rd | input | 1 | Read strobe of the receive register |
| rx_data | output | DATA_W | Last received byte |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |
| bus_busy | output | 1 | Bus busy status |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 7-bit address and two synchronizer stages. Under these values the direction bit lands in bit 0 of the address byte, and edges are seen three system cycles after a line changes. An open-drain bus model lets the bench master stall against the held clock line. This puts the hold-until-read release, acknowledge inhibit, address mismatch, read direction and disabled operation all within reach. Asymmetric data bytes such as 0x01 and 0x80 show the shift order.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } srx_state_e;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  // Idle bus lines are high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              cfg_enable,
  input  logic              cfg_irq_en,
  input  logic              cfg_ack_inhibit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              flag_clr,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq_flag,
  output logic              irq,
  output logic              bus_busy
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int DIR_B  = DATA_W - ADDR_W - 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_srx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(line_s)
  );

  i2c_srx_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  srx_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d, rx_q, rx_d;
  logic              first_q, first_d;
  logic              sda_pull_q, sda_pull_d, scl_pull_q, scl_pull_d;
  logic              flag_q, flag_d, busy_q, busy_d, flag_set;
  logic              addr_ok;

  assign addr_ok = (shift_q[DATA_W-1 -: ADDR_W] == own_addr) && !shift_q[DIR_B];

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shift_d    = shift_q;
    rx_d       = rx_q;
    first_d    = first_q;
    sda_pull_d = sda_pull_q;
    scl_pull_d = scl_pull_q;
    flag_set   = 1'b0;
    if (!cfg_enable) begin
      state_d    = ST_IDLE;
      sda_pull_d = 1'b0;
      scl_pull_d = 1'b0;
    end else if (start_det) begin
      state_d    = ST_RECV;
      cnt_d      = '0;
      first_d    = 1'b1;
      sda_pull_d = 1'b0;
      scl_pull_d = 1'b0;
    end else if (stop_det) begin
      state_d    = ST_IDLE;
      sda_pull_d = 1'b0;
      scl_pull_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            shift_d = {shift_q[DATA_W-2:0], line_s[0]};
            cnt_d   = cnt_q + CNT_W'(1);
          end
          if (scl_fall && cnt_q == LAST_BIT) begin
            if (first_q && !addr_ok) begin
              state_d = ST_SKIP;
            end else begin
              state_d    = ST_ACK;
              sda_pull_d = !cfg_ack_inhibit;
            end
          end
        end
        ST_ACK: begin
          if (scl_rise) begin
            flag_set = 1'b1;
            rx_d     = shift_q;
          end
          if (scl_fall) begin
            state_d    = ST_HOLD;
            sda_pull_d = 1'b0;
            scl_pull_d = 1'b1;
          end
        end
        ST_HOLD: begin
          if (data_rd) begin
            state_d    = ST_RECV;
            cnt_d      = '0;
            first_d    = 1'b0;
            scl_pull_d = 1'b0;
          end
        end
        default: ;
      endcase
    end

    busy_d = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;

    flag_d = flag_q;
    if (flag_set)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      rx_q       <= '0;
      first_q    <= 1'b0;
      sda_pull_q <= 1'b0;
      scl_pull_q <= 1'b0;
      flag_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      shift_q    <= shift_d;
      rx_q       <= rx_d;
      first_q    <= first_d;
      sda_pull_q <= sda_pull_d;
      scl_pull_q <= scl_pull_d;
      flag_q     <= flag_d;
      busy_q     <= busy_d;
    end
  end

  assign scl_pull_o = scl_pull_q;
  assign sda_pull_o = sda_pull_q;
  assign rx_data    = rx_q;
  assign irq_flag   = flag_q;
  assign irq        = flag_q & cfg_irq_en;
  assign bus_busy   = busy_q;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy); // R1
  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy); // R2
  AST_QUIET_WHEN_SKIPPING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP || state_q == ST_IDLE) |-> (!sda_pull_o && !scl_pull_o)); // R3
  AST_ACK_RESPECTS_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !cfg_ack_inhibit); // R4
  AST_FLAG_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(scl_rise)); // R5
  AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o && !data_rd && cfg_enable && !start_det && !stop_det) |=> scl_pull_o); // R6
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o && data_rd) |=> !scl_pull_o); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!sda_pull_o && !scl_pull_o)); // R9
endmodule

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;
  localparam int Q     = 10;
  localparam int HOSTW = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  wire  scl_line, sda_line;
  logic scl_pull_o, sda_pull_o;
  logic cfg_enable, cfg_irq_en, cfg_ack_inhibit;
  logic [6:0] own_addr;
  logic flag_clr, data_rd;
  logic [7:0] rx_data;
  logic irq_flag, irq, bus_busy;

  int n_chk = 0;
  int n_err = 0;
  int n_seen = 0;
  logic pull_seen = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign scl_line = m_scl & ~scl_pull_o;
  assign sda_line = m_sda & ~sda_pull_o;

  i2c_slave_rx u_i2c_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .cfg_enable(cfg_enable), .cfg_irq_en(cfg_irq_en), .cfg_ack_inhibit(cfg_ack_inhibit),
    .own_addr(own_addr), .flag_clr(flag_clr), .data_rd(data_rd),
    .rx_data(rx_data), .irq_flag(irq_flag), .irq(irq), .bus_busy(bus_busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1;
    wait (scl_line === 1'b1);
    wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wq(Q);
    m_scl = 1'b1;
    wait (scl_line === 1'b1);
    wq(Q);
    s = sda_line;
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  // Driver: pushes the expected byte before putting it on the bus
  task automatic send_byte(input logic [7:0] d, input logic accept, output logic ack);
    logic dummy;
    if (accept) exp_q.push_back(d);
    for (int i = 7; i >= 0; i--) clk_bit(d[i], dummy);
    clk_bit(1'b1, ack);
  endtask

  // Monitor and host: pops expected bytes as the design raises its flag
  initial begin
    logic [7:0] e;
    flag_clr = 1'b0;
    data_rd  = 1'b0;
    forever begin
      wait (rst_n === 1'b1 && irq_flag === 1'b1);
      @(negedge clk);
      n_seen++;
      if (exp_q.size() == 0) begin
        chk("R8 byte delivered without expectation", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk("R8 rx_data msb-first byte", rx_data, e);
      end
      chk("R5 irq equals flag and enable", irq, cfg_irq_en);
      wait (scl_pull_o === 1'b1);
      wq(HOSTW);
      chk("R6 clock held before read", {scl_pull_o, scl_line}, 2'b10);
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      chk("R7 flag cleared by pulse", irq_flag, 0);
      data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
      chk("R6 clock released after read", scl_pull_o, 0);
    end
  end

  always @(negedge clk) if (scl_pull_o || sda_pull_o) pull_seen <= 1'b1;

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    int base;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    cfg_enable = 1'b1; cfg_irq_en = 1'b1; cfg_ack_inhibit = 1'b0; own_addr = 7'h5A;
    wq(5);
    chk("R1 reset state", {bus_busy, irq_flag, scl_pull_o, sda_pull_o, rx_data}, 0);
    rst_n = 1'b1; wq(5);

    // Accepted write with several data patterns
    bus_start(); wq(2);
    chk("R1 busy after start", bus_busy, 1);
    send_byte({7'h5A, 1'b0}, 1'b1, ack); chk("R3 address acknowledged", ack, 0);
    send_byte(8'hA5, 1'b1, ack);         chk("R3 data acknowledged", ack, 0);
    send_byte(8'h01, 1'b1, ack);         chk("R8 data 01 acknowledged", ack, 0);
    send_byte(8'h3C, 1'b1, ack);         chk("R7 continuous reception ack", ack, 0);
    bus_stop(); wq(4);
    chk("R2 busy cleared by stop", bus_busy, 0);
    chk("R7 four bytes handled", n_seen, 4);

    // Address mismatch
    base = n_seen; pull_seen = 1'b0;
    bus_start();
    send_byte({7'h5B, 1'b0}, 1'b0, ack); chk("R3 mismatch not acknowledged", ack, 1);
    send_byte(8'h00, 1'b0, ack);
    bus_stop(); wq(4);
    chk("R3 mismatch no flag", n_seen, base);
    chk("R3 mismatch lines untouched", pull_seen, 0);

    // Read direction
    base = n_seen; pull_seen = 1'b0;
    bus_start();
    send_byte({7'h5A, 1'b1}, 1'b0, ack); chk("R3 read direction refused", ack, 1);
    bus_stop(); wq(4);
    chk("R3 read direction no pull", {pull_seen, 24'(n_seen - base)}, 0);

    // Acknowledge inhibited
    cfg_ack_inhibit = 1'b1; base = n_seen;
    bus_start();
    send_byte({7'h5A, 1'b0}, 1'b1, ack); chk("R4 no acknowledge when inhibited", ack, 1);
    bus_stop(); wq(4);
    chk("R4 byte still delivered", n_seen - base, 1);
    cfg_ack_inhibit = 1'b0;

    // Interrupt disabled
    cfg_irq_en = 1'b0; base = n_seen;
    bus_start();
    send_byte({7'h5A, 1'b0}, 1'b1, ack);
    send_byte(8'h80, 1'b1, ack); chk("R5 data acked with irq masked", ack, 0);
    bus_stop(); wq(4);
    chk("R5 flags seen with irq masked", n_seen - base, 2);
    cfg_irq_en = 1'b1;

    // Disabled block
    cfg_enable = 1'b0; base = n_seen; pull_seen = 1'b0;
    bus_start(); wq(2);
    chk("R1 busy tracked while disabled", bus_busy, 1);
    send_byte({7'h5A, 1'b0}, 1'b0, ack); chk("R9 disabled no acknowledge", ack, 1);
    bus_stop(); wq(4);
    chk("R9 disabled no flag or pull", {pull_seen, 24'(n_seen - base)}, 0);
    chk("R8 all expected bytes consumed", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule